// File: doc/BRIEF.md
# Source-Routed Network Interface for a Packet Network

This block connects one master or slave port of a core to an on-chip packet network. On the send side it accepts a memory-style request: a read or a write, a start address, a burst length and a destination number. It turns each beat of the burst into its own packet. Every packet has the same fixed length of three flits: a header, one body flit and a tail. The route is stored per destination in a small local table. It is copied into the header, so the switches only follow the hop list and never compute a path. Write data arrives beat by beat on a separate data handshake and travels in the tail flit.

On the receive side the block accepts a flit stream, rebuilds response packets and issues one response pulse for each well-formed packet. The pulse carries the address from the body flit and the data from the tail flit. A flit that arrives with no open packet is discarded and sets a sticky error flag. Each flit is `{kind[1:0], vc, payload}`. The kind codes are 00 for a header, 01 for a body, 10 for a tail, and 11 is reserved.

Send states: `TX_IDLE` waits for a request and moves to `TX_HEAD` when one is accepted. `TX_HEAD` moves to `TX_BODY` after its flit handshake. `TX_BODY` moves to `TX_TAIL` after its flit handshake. `TX_TAIL` returns to `TX_HEAD` for the next beat, or to `TX_IDLE` after the last beat. Receive states: `RX_WAIT` (no packet open) goes to `RX_OPEN` on a header. `RX_OPEN` returns to `RX_WAIT` on a tail. In `RX_OPEN` a new header restarts the packet.

Top module: `noc_src_ni`

## Requirements
- R1: After reset, req_ready is 1, tx_valid is 0, rsp_valid is 0 and rx_err is 0.
- R2: Writing the route table at index d stores a route. Every header sent to destination d then carries exactly that route.
- R3: Every beat is sent as exactly three flits in this order: kind 00, then kind 01, then kind 10. Every flit's vc field equals the TX_VC parameter (default 1).
- R4: The header payload holds the route in bits [31:16], the destination in [15:12], the write flag in [11] and the beat index in [3:0]. Bits [10:4] are zero.
- R5: The body payload is the beat address. This is the start address plus the beat index times DATA_W/8.
- R6: A request with length field L produces L+1 packets with beat indices 0..L. req_ready stays low from acceptance until the last tail handshake.
- R7: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_flit stays unchanged on the next cycle. No flit is lost or repeated.
- R8: For a write, each tail payload is the wd_data word taken by a wd_valid/wd_ready handshake during that tail, so beat k uses the k-th word. For a read, the tail payload is zero and wd_ready stays low.
- R9: A header, then a body carrying address A, then a tail carrying data D produce a one-cycle rsp_valid pulse in the cycle after the tail, with rsp_addr=A and rsp_data=D.
- R10: A body or tail flit with no open packet is dropped. It produces no response and sets rx_err, which stays set until reset.
- R11: A flit of kind 11 is dropped and sets rx_err.
- R12: A header that arrives while a packet is open restarts the packet without an error. The response then uses the body of the restarted packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rt_we | input | 1 | Route table write strobe |
| rt_dest | input | DEST_W | Route table entry index |
| rt_route | input | ROUTE_W | Hop list to store |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dest | input | DEST_W | Destination number |
| req_addr | input | ADDR_W | Start address |
| req_len | input | LEN_W | Beats minus one |
| wd_valid | input | 1 | Write data word offered |
| wd_ready | output | 1 | Write data word taken |
| wd_data | input | DATA_W | Write data word |
| tx_valid | output | 1 | Outgoing flit valid |
| tx_ready | input | 1 | Network accepts flit |
| tx_flit | output | FLIT_W | Outgoing flit |
| rx_valid | input | 1 | Incoming flit valid |
| rx_flit | input | FLIT_W | Incoming flit |
| rsp_valid | output | 1 | Response pulse |
| rsp_addr | output | ADDR_W | Response address |
| rsp_data | output | DATA_W | Response data |
| rx_err | output | 1 | Sticky receive framing error |

## Verification
The send-side properties assume that the network side may lower tx_ready at any cycle, and that write data may arrive late. The receive-side properties assume that rx_valid qualifies each flit for exactly one cycle and that no back-pressure exists on receive. The stimulus drives every input shortly after a rising edge. It throttles tx_ready in a repeating pattern during bursts. It gives the receive side a separate single-cycle pulse for each flit, and these include malformed orders: orphan flits, reserved kinds and repeated headers.

// File: rtl/noc_ni_pkg.sv
package noc_ni_pkg;
    typedef enum logic [1:0] {
        FK_HEAD = 2'b00,
        FK_BODY = 2'b01,
        FK_TAIL = 2'b10,
        FK_RSVD = 2'b11
    } flit_kind_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_HEAD,
        TX_BODY,
        TX_TAIL
    } tx_state_t;

    typedef enum logic {
        RX_WAIT,
        RX_OPEN
    } rx_state_t;
endpackage

// File: rtl/ni_route_table.sv
module ni_route_table #(
    parameter int DEST_W  = 4,
    parameter int ROUTE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [DEST_W-1:0]  wr_idx,
    input  logic [ROUTE_W-1:0] wr_route,
    input  logic [DEST_W-1:0]  rd_idx,
    output logic [ROUTE_W-1:0] rd_route
);
    localparam int ENTRIES = 1 << DEST_W;

    logic [ROUTE_W-1:0] tbl [ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
        end else if (wr_en) begin
            tbl[wr_idx] <= wr_route;
        end
    end

    assign rd_route = tbl[rd_idx];
endmodule

// File: rtl/ni_tx_packer.sv
module ni_tx_packer
    import noc_ni_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int LEN_W   = 4,
    parameter int DEST_W  = 4,
    parameter int ROUTE_W = 16,
    parameter int VC_W    = 1,
    parameter logic [VC_W-1:0] TX_VC = 1,
    parameter int PAY_W   = 32,
    localparam int FLIT_W = 2 + VC_W + PAY_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [DEST_W-1:0]  req_dest,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [LEN_W-1:0]   req_len,
    input  logic [ROUTE_W-1:0] lut_route,
    input  logic               wd_valid,
    output logic               wd_ready,
    input  logic [DATA_W-1:0]  wd_data,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic [FLIT_W-1:0]  tx_flit
);
    localparam int BYTES  = DATA_W / 8;
    localparam int WR_BIT = PAY_W - ROUTE_W - DEST_W - 1;

    tx_state_t          st, st_nx;
    logic               wr_q;
    logic [DEST_W-1:0]  dest_q;
    logic [ROUTE_W-1:0] route_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [LEN_W-1:0]   len_q;
    logic [LEN_W-1:0]   beat_q;
    logic               fire;
    logic [PAY_W-1:0]   pay;
    flit_kind_t         kind;

    assign fire = tx_valid && tx_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= TX_IDLE;
            wr_q    <= 1'b0;
            dest_q  <= '0;
            route_q <= '0;
            addr_q  <= '0;
            len_q   <= '0;
            beat_q  <= '0;
        end else begin
            st <= st_nx;
            if (st == TX_IDLE && req_valid) begin
                wr_q    <= req_write;
                dest_q  <= req_dest;
                route_q <= lut_route;
                addr_q  <= req_addr;
                len_q   <= req_len;
                beat_q  <= '0;
            end
            if (st == TX_TAIL && fire && beat_q != len_q) begin
                beat_q <= beat_q + 1'b1;
                addr_q <= addr_q + ADDR_W'(BYTES);
            end
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            TX_IDLE: if (req_valid) st_nx = TX_HEAD;
            TX_HEAD: if (fire) st_nx = TX_BODY;
            TX_BODY: if (fire) st_nx = TX_TAIL;
            TX_TAIL: if (fire) st_nx = (beat_q == len_q) ? TX_IDLE : TX_HEAD;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        tx_valid  = 1'b0;
        wd_ready  = 1'b0;
        kind      = FK_HEAD;
        pay       = '0;
        unique case (st)
            TX_IDLE: req_ready = 1'b1;
            TX_HEAD: begin
                tx_valid = 1'b1;
                pay[PAY_W-1 -: ROUTE_W]          = route_q;
                pay[PAY_W-ROUTE_W-1 -: DEST_W]   = dest_q;
                pay[WR_BIT]                      = wr_q;
                pay[LEN_W-1:0]                   = beat_q;
            end
            TX_BODY: begin
                tx_valid = 1'b1;
                kind     = FK_BODY;
                pay[ADDR_W-1:0] = addr_q;
            end
            TX_TAIL: begin
                kind     = FK_TAIL;
                tx_valid = !wr_q || wd_valid;
                wd_ready = wr_q && tx_ready;
                if (wr_q) pay[DATA_W-1:0] = wd_data;
            end
        endcase
        tx_flit = {kind, TX_VC, pay};
    end

    // R7: a stalled flit is held unchanged
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_flit)));

    // R3: a sent header is followed by a body flit
    p_head_then_body_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && tx_flit[FLIT_W-1 -: 2] == FK_HEAD) |=> (tx_flit[FLIT_W-1 -: 2] == FK_BODY));

    // R8: write data is only taken while a tail is presented
    p_wd_in_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wd_ready |-> (tx_flit[FLIT_W-1 -: 2] == FK_TAIL));

    // R6: no new request is accepted while flits are being sent
    p_quiet_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !tx_valid);
endmodule

// File: rtl/ni_rx_unpacker.sv
module ni_rx_unpacker
    import noc_ni_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int VC_W   = 1,
    parameter int PAY_W  = 32,
    localparam int FLIT_W = 2 + VC_W + PAY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [FLIT_W-1:0] rx_flit,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rx_err
);
    rx_state_t         st, st_nx;
    flit_kind_t        kind;
    logic [PAY_W-1:0]  pay;
    logic [ADDR_W-1:0] addr_q;
    logic              rsp_set, err_set, cap_addr, clr_addr;

    assign kind = flit_kind_t'(rx_flit[FLIT_W-1 -: 2]);
    assign pay  = rx_flit[PAY_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= RX_WAIT;
            addr_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            rsp_data  <= '0;
            rx_err    <= 1'b0;
        end else begin
            st        <= st_nx;
            rsp_valid <= rsp_set;
            if (err_set) rx_err <= 1'b1;
            if (clr_addr) addr_q <= '0;
            else if (cap_addr) addr_q <= pay[ADDR_W-1:0];
            if (rsp_set) begin
                rsp_addr <= addr_q;
                rsp_data <= pay[DATA_W-1:0];
            end
        end
    end

    always_comb begin
        st_nx    = st;
        rsp_set  = 1'b0;
        err_set  = 1'b0;
        cap_addr = 1'b0;
        clr_addr = 1'b0;
        if (rx_valid) begin
            unique case (kind)
                FK_HEAD: begin
                    st_nx    = RX_OPEN;
                    clr_addr = 1'b1;
                end
                FK_BODY: begin
                    if (st == RX_OPEN) cap_addr = 1'b1;
                    else               err_set  = 1'b1;
                end
                FK_TAIL: begin
                    if (st == RX_OPEN) begin
                        rsp_set = 1'b1;
                        st_nx   = RX_WAIT;
                    end else begin
                        err_set = 1'b1;
                    end
                end
                FK_RSVD: err_set = 1'b1;
            endcase
        end
    end

    // R10: the error flag never clears outside reset
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |=> rx_err);

    // R9: a response follows a received tail flit
    p_rsp_after_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(rx_valid && rx_flit[FLIT_W-1 -: 2] == FK_TAIL));

    // R10: an orphan body raises the error and gives no response
    p_orphan_body_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && kind == FK_BODY && st == RX_WAIT) |=> (rx_err && !rsp_valid));
endmodule

// File: rtl/noc_src_ni.sv
module noc_src_ni #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int LEN_W   = 4,
    parameter int DEST_W  = 4,
    parameter int ROUTE_W = 16,
    parameter int VC_W    = 1,
    parameter logic [VC_W-1:0] TX_VC = 1,
    localparam int PAY_W  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W,
    localparam int FLIT_W = 2 + VC_W + PAY_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rt_we,
    input  logic [DEST_W-1:0]  rt_dest,
    input  logic [ROUTE_W-1:0] rt_route,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [DEST_W-1:0]  req_dest,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [LEN_W-1:0]   req_len,
    input  logic               wd_valid,
    output logic               wd_ready,
    input  logic [DATA_W-1:0]  wd_data,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic [FLIT_W-1:0]  tx_flit,
    input  logic               rx_valid,
    input  logic [FLIT_W-1:0]  rx_flit,
    output logic               rsp_valid,
    output logic [ADDR_W-1:0]  rsp_addr,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               rx_err
);
    logic [ROUTE_W-1:0] lut_route;

    ni_route_table #(.DEST_W(DEST_W), .ROUTE_W(ROUTE_W)) u_rt (
        .clk(clk), .rst_n(rst_n),
        .wr_en(rt_we), .wr_idx(rt_dest), .wr_route(rt_route),
        .rd_idx(req_dest), .rd_route(lut_route)
    );

    ni_tx_packer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .DEST_W(DEST_W),
        .ROUTE_W(ROUTE_W), .VC_W(VC_W), .TX_VC(TX_VC), .PAY_W(PAY_W)
    ) u_tx (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_dest(req_dest), .req_addr(req_addr), .req_len(req_len),
        .lut_route(lut_route),
        .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_flit(tx_flit)
    );

    ni_rx_unpacker #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VC_W(VC_W), .PAY_W(PAY_W)
    ) u_rx (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_flit(rx_flit),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
        .rx_err(rx_err)
    );
endmodule

// File: tb/sim_noc_src_ni.sv
module sim_noc_src_ni;
    localparam int FW = 35;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rt_we = 1'b0;
    logic [3:0] rt_dest = '0;
    logic [15:0] rt_route = '0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic req_ready;
    logic [3:0] req_dest = '0;
    logic [31:0] req_addr = '0;
    logic [3:0] req_len = '0;
    logic wd_valid = 1'b1;
    logic wd_ready;
    logic [31:0] wd_data;
    logic tx_valid;
    logic tx_ready = 1'b1;
    logic [FW-1:0] tx_flit;
    logic rx_valid = 1'b0;
    logic [FW-1:0] rx_flit = '0;
    logic rsp_valid;
    logic [31:0] rsp_addr, rsp_data;
    logic rx_err;

    int total = 0, bad = 0;
    logic [FW-1:0] log_f [64];
    int nflit = 0;
    int rsp_cnt = 0;
    logic [31:0] last_addr, last_data;
    logic [31:0] wq [8];
    int widx = 0;
    logic throttle = 1'b0;
    int cyc = 0;

    noc_src_ni u0 (
        .clk(clk), .rst_n(rst_n), .rt_we(rt_we), .rt_dest(rt_dest), .rt_route(rt_route),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_dest(req_dest), .req_addr(req_addr), .req_len(req_len),
        .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_flit(tx_flit),
        .rx_valid(rx_valid), .rx_flit(rx_flit),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data), .rx_err(rx_err)
    );

    always #5 clk = ~clk;

    assign wd_data = wq[widx];

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // flit monitor, stall hold check (R7), write data and response tracking
    logic prev_stall = 1'b0;
    logic [FW-1:0] prev_flit;
    always begin
        @(negedge clk);
        if (prev_stall) begin
            check("R7 held valid", {63'd0, tx_valid}, 64'd1);
            check("R7 held flit", 64'(tx_flit), 64'(prev_flit));
        end
        prev_stall = rst_n && tx_valid && !tx_ready;
        prev_flit  = tx_flit;
        if (rst_n && tx_valid && tx_ready) begin
            log_f[nflit] = tx_flit;
            nflit++;
        end
        if (rsp_valid) begin
            rsp_cnt++;
            last_addr = rsp_addr;
            last_data = rsp_data;
        end
        if (rst_n && wd_valid && wd_ready) begin
            @(posedge clk); #1;
            widx++;
        end
    end

    always begin
        @(posedge clk); #1;
        cyc++;
        tx_ready = throttle ? (cyc % 3 != 0) : 1'b1;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic [FW-1:0] mk(logic [1:0] k, logic [31:0] p);
        return {k, 1'b1, p};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 req_ready", {63'd0, req_ready}, 64'd1);
        check("R1 tx_valid", {63'd0, tx_valid}, 64'd0);
        check("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
        check("R1 rx_err", {63'd0, rx_err}, 64'd0);
    endtask

    task automatic load_rt(logic [3:0] d, logic [15:0] r);
        @(posedge clk); #1;
        rt_we = 1'b1; rt_dest = d; rt_route = r;
        @(posedge clk); #1;
        rt_we = 1'b0;
    endtask

    // R2 R3 R4 R5 R6 R8: send one request and compare all flits
    task automatic t_request(logic wr, logic [3:0] d, logic [15:0] r, logic [31:0] a,
                             logic [3:0] len, int wbase);
        int start, busy;
        start = nflit;
        busy = 0;
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_dest = d; req_addr = a; req_len = len;
        @(posedge clk); #1;
        req_valid = 1'b0;
        while (nflit < start + 3 * (int'(len) + 1)) begin
            @(negedge clk);
            if (req_ready && nflit < start + 3 * (int'(len) + 1)) busy++;
        end
        check("R6 req_ready low while busy", 64'(busy), 64'd0);
        for (int b = 0; b <= int'(len); b++) begin
            check("R2 R4 header", 64'(log_f[start + 3*b]),
                  64'(mk(2'b00, {r, d, wr, 7'd0, 4'(b)})));
            check("R3 R5 body", 64'(log_f[start + 3*b + 1]),
                  64'(mk(2'b01, a + 32'(4*b))));
            check("R3 R8 tail", 64'(log_f[start + 3*b + 2]),
                  64'(mk(2'b10, wr ? wq[wbase + b] : 32'd0)));
        end
        repeat (2) @(negedge clk);
        check("R6 no extra flits", 64'(nflit), 64'(start + 3 * (int'(len) + 1)));
        check("R6 idle again", {63'd0, req_ready}, 64'd1);
    endtask

    task automatic send_rx(logic [1:0] k, logic [31:0] p);
        @(posedge clk); #1;
        rx_valid = 1'b1; rx_flit = {k, 1'b0, p};
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic t_rx_normal();
        int c0;
        c0 = rsp_cnt;
        send_rx(2'b00, 32'h0);
        send_rx(2'b01, 32'h0000_0044);
        send_rx(2'b10, 32'hCAFE_0001);
        repeat (2) @(negedge clk);
        check("R9 one response", 64'(rsp_cnt - c0), 64'd1);
        check("R9 rsp_addr", 64'(last_addr), 64'h44);
        check("R9 rsp_data", 64'(last_data), 64'hCAFE_0001);
        check("R9 no error", {63'd0, rx_err}, 64'd0);
    endtask

    task automatic t_rx_restart();
        int c0;
        c0 = rsp_cnt;
        send_rx(2'b00, 32'h0);
        send_rx(2'b01, 32'h0000_0010);
        send_rx(2'b00, 32'h0);
        send_rx(2'b01, 32'h0000_0020);
        send_rx(2'b10, 32'h0000_0055);
        repeat (2) @(negedge clk);
        check("R12 one response", 64'(rsp_cnt - c0), 64'd1);
        check("R12 restarted addr", 64'(last_addr), 64'h20);
        check("R12 no error", {63'd0, rx_err}, 64'd0);
    endtask

    task automatic t_rx_orphan();
        int c0;
        c0 = rsp_cnt;
        send_rx(2'b01, 32'h0000_0077);
        repeat (2) @(negedge clk);
        check("R10 orphan body error", {63'd0, rx_err}, 64'd1);
        send_rx(2'b10, 32'h0000_0088);
        repeat (3) @(negedge clk);
        check("R10 no response", 64'(rsp_cnt - c0), 64'd0);
        check("R10 error sticky", {63'd0, rx_err}, 64'd1);
    endtask

    task automatic t_rx_reserved();
        int c0;
        do_reset();
        @(negedge clk);
        check("R11 error clear after reset", {63'd0, rx_err}, 64'd0);
        c0 = rsp_cnt;
        send_rx(2'b11, 32'h0000_0099);
        repeat (2) @(negedge clk);
        check("R11 reserved sets error", {63'd0, rx_err}, 64'd1);
        check("R11 no response", 64'(rsp_cnt - c0), 64'd0);
    endtask

    initial begin
        wq[0] = 32'hDEAD_BEEF; wq[1] = 32'h1111_2222; wq[2] = 32'h3333_4444;
        wq[3] = 32'h0; wq[4] = 32'h0; wq[5] = 32'h0; wq[6] = 32'h0; wq[7] = 32'h0;
        do_reset();
        t_reset();
        load_rt(4'd3, 16'hA5C3);
        load_rt(4'd5, 16'h0F1E);
        t_request(1'b1, 4'd3, 16'hA5C3, 32'h1000_0000, 4'd0, 0);
        throttle = 1'b1;
        t_request(1'b0, 4'd5, 16'h0F1E, 32'h2000_0010, 4'd2, 0);
        t_request(1'b1, 4'd3, 16'hA5C3, 32'h3000_0000, 4'd1, 1);
        throttle = 1'b0;
        check("R8 words consumed", 64'(widx), 64'd3);
        t_rx_normal();
        t_rx_restart();
        t_rx_orphan();
        t_rx_reserved();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule